// File: doc/BRIEF.md
# Superscalar Co-Issue Selector

This block sits between the decoder and the ALUs of one shader lane. The lane has two single-precision (FP32) ALUs and a group of half-precision (FP16) ALUs, four by default or two in the smaller build. In each issue slot the selector looks at a short window of decoded instructions from one thread. It issues the longest run from the head of the window that the lane can execute together. The run has to be all one precision, fit in that class's ALUs, and contain no instruction that depends on an earlier member of the run.

Each window entry carries a valid flag, a precision bit, a destination register number and two source register numbers. The selector returns registered results: one enable and one window index for each ALU, the number of entries taken, and a stall flag for an empty window. The decode stage shifts the window by the taken count on the following cycle.

Top module: `cois_selector`

## Requirements
- R1: Whenever window entry 0 is valid, the taken count produced for that window is at least 1.
- R2: When entry 0 is not valid, the result is a stall: `stall` is 1, the taken count is 0 and every ALU enable is 0.
- R3: An FP32 group never exceeds two instructions.
- R4: An FP16 group never exceeds `N_F16` instructions (4 by default).
- R5: The precision bit of entry 0 (0 = FP32, 1 = FP16) fixes the class of the group, and the first entry of the other class ends it.
- R6: An entry whose source A or source B equals the destination of an earlier entry in the group ends the group, and that entry is not taken.
- R7: An entry whose destination equals the destination of an earlier entry in the group ends the group, and that entry is not taken.
- R8: Entries are taken strictly in order from entry 0. The first invalid entry ends the group and no later entry is skipped to.
- R9: Register number 0 takes part in the conflict checks like any other register.
- R10: If the group has n entries, ALUs 0..n-1 of its class are enabled and ALU k reports window index k. All other ALUs are disabled and report index 0.
- R11: All outputs are registered. During reset they are 0. After reset they describe the window that was present before the latest rising clock edge.
- R12: Four consecutive independent FP16 entries are issued together, so all four FP16 ALUs are in use.
- R13: With `N_F16` = 2, the same FP16 stream is issued at most two at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| win_valid | input | W | Per-entry valid flag, bit 0 is the head |
| win_fp16 | input | W | Per-entry precision, 1 = FP16 |
| win_dst | input | W*RW | Destination register per entry, entry k at bits k*RW |
| win_src_a | input | W*RW | First source register per entry |
| win_src_b | input | W*RW | Second source register per entry |
| fp32_issue | output | N_F32 | FP32 ALU enables |
| fp32_slot | output | N_F32*IW | Window index per FP32 ALU |
| fp16_issue | output | N_F16 | FP16 ALU enables |
| fp16_slot | output | N_F16*IW | Window index per FP16 ALU |
| take_cnt | output | CW | Entries consumed from the window |
| stall | output | 1 | Empty window, nothing issued |

## Verification
The hardest case to reach is a group that ends for exactly one reason while the other stopping conditions stay clear. For example, a read-after-write on entry 2 in a pure FP16 window, with no capacity limit and no precision change before it. Directed windows set up each stopping cause on its own, using distinct registers so that nothing else interferes. The random windows draw register numbers mostly from a set of four, so that hazards at different depths happen often. The reference model records which rule ended each group, and each check is reported against that rule.

// File: rtl/cois_pkg.sv
package cois_pkg;
  typedef enum logic {PREC_F32 = 1'b0, PREC_F16 = 1'b1} prec_e;
endpackage

// File: rtl/cois_rst_sync.sv
module cois_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/cois_hazard.sv
// Flags every window entry that conflicts with any older entry:
// read-after-write on either source, or write-after-write.
module cois_hazard #(
  parameter int W  = 4,
  parameter int RW = 5
) (
  input  logic [W*RW-1:0] dst,
  input  logic [W*RW-1:0] src_a,
  input  logic [W*RW-1:0] src_b,
  output logic [W-1:0]    blocked
);
  logic [W-1:0][W-1:0] pair;

  genvar gj, gi;
  generate
    for (gj = 0; gj < W; gj++) begin : g_young
      for (gi = 0; gi < W; gi++) begin : g_old
        if (gi < gj) begin : g_cmp
          assign pair[gj][gi] =
              (dst[gi*RW +: RW] == src_a[gj*RW +: RW]) ||
              (dst[gi*RW +: RW] == src_b[gj*RW +: RW]) ||
              (dst[gi*RW +: RW] == dst[gj*RW +: RW]);
        end else begin : g_none
          assign pair[gj][gi] = 1'b0;
        end
      end
      assign blocked[gj] = |pair[gj];
    end
  endgenerate
endmodule

// File: rtl/cois_group.sv
// Length of the in-order run from the head that can issue together.
module cois_group
  import cois_pkg::*;
#(
  parameter int W     = 4,
  parameter int N_F32 = 2,
  parameter int N_F16 = 4,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic [W-1:0]  valid,
  input  logic [W-1:0]  fp16,
  input  logic [W-1:0]  blocked,
  output prec_e         head_cls,
  output logic [CW-1:0] cnt
);
  int   cap;
  logic run;
  logic take;

  assign head_cls = fp16[0] ? PREC_F16 : PREC_F32;

  always_comb begin
    cap  = fp16[0] ? N_F16 : N_F32;
    run  = 1'b1;
    take = 1'b0;
    cnt  = '0;
    for (int j = 0; j < W; j++) begin
      take = run && valid[j] && (fp16[j] == fp16[0]) && !blocked[j] && (j < cap);
      if (take) cnt = CW'(j + 1);
      run = take;
    end
  end
endmodule

// File: rtl/cois_selector.sv
module cois_selector
  import cois_pkg::*;
#(
  parameter int W     = 4,
  parameter int RW    = 5,
  parameter int N_F32 = 2,
  parameter int N_F16 = 4,
  localparam int IW   = (W > 1) ? $clog2(W) : 1,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       win_valid,
  input  logic [W-1:0]       win_fp16,
  input  logic [W*RW-1:0]    win_dst,
  input  logic [W*RW-1:0]    win_src_a,
  input  logic [W*RW-1:0]    win_src_b,
  output logic [N_F32-1:0]   fp32_issue,
  output logic [N_F32*IW-1:0] fp32_slot,
  output logic [N_F16-1:0]   fp16_issue,
  output logic [N_F16*IW-1:0] fp16_slot,
  output logic [CW-1:0]      take_cnt,
  output logic               stall
);
  logic          rstn_q;
  logic [W-1:0]  blocked;
  prec_e         head_cls;
  logic [CW-1:0] cnt_d;
  logic [N_F32-1:0]    f32_d;
  logic [N_F32*IW-1:0] s32_d;
  logic [N_F16-1:0]    f16_d;
  logic [N_F16*IW-1:0] s16_d;
  logic          stall_d;
  logic          upd_en;

  cois_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rstn_q));

  cois_hazard #(.W(W), .RW(RW)) u_haz (
    .dst(win_dst), .src_a(win_src_a), .src_b(win_src_b), .blocked(blocked)
  );

  cois_group #(.W(W), .N_F32(N_F32), .N_F16(N_F16)) u_grp (
    .valid(win_valid), .fp16(win_fp16), .blocked(blocked),
    .head_cls(head_cls), .cnt(cnt_d)
  );

  // next-state
  always_comb begin
    upd_en  = 1'b1;
    stall_d = !win_valid[0];
    for (int a = 0; a < N_F32; a++) begin
      f32_d[a] = (head_cls == PREC_F32) && (int'(cnt_d) > a);
      s32_d[a*IW +: IW] = f32_d[a] ? IW'(a) : '0;
    end
    for (int a = 0; a < N_F16; a++) begin
      f16_d[a] = (head_cls == PREC_F16) && (int'(cnt_d) > a);
      s16_d[a*IW +: IW] = f16_d[a] ? IW'(a) : '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rstn_q) begin
    if (!rstn_q) begin
      fp32_issue <= '0;
      fp32_slot  <= '0;
      fp16_issue <= '0;
      fp16_slot  <= '0;
      take_cnt   <= '0;
      stall      <= 1'b0;
    end else if (upd_en) begin
      fp32_issue <= f32_d;
      fp32_slot  <= s32_d;
      fp16_issue <= f16_d;
      fp16_slot  <= s16_d;
      take_cnt   <= cnt_d;
      stall      <= stall_d;
    end
  end

  // R1
  head_valid_chk: assert property (@(posedge clk) disable iff (!rstn_q)
    win_valid[0] |=> take_cnt != '0);

  // R2
  empty_stall_chk: assert property (@(posedge clk) disable iff (!rstn_q)
    !win_valid[0] |=> stall && take_cnt == '0 && fp32_issue == '0 && fp16_issue == '0);

  // R3
  fp32_cap_chk: assert property (@(posedge clk) disable iff (!rstn_q)
    (|fp32_issue) |-> int'(take_cnt) <= N_F32);

  // R5
  class_mix_chk: assert property (@(posedge clk) disable iff (!rstn_q)
    !((|fp32_issue) && (|fp16_issue)));

  // R6
  raw_pair_chk: assert property (@(posedge clk) disable iff (!rstn_q)
    (win_valid[0] && win_valid[1] &&
     (win_dst[RW-1:0] == win_src_a[2*RW-1:RW] || win_dst[RW-1:0] == win_src_b[2*RW-1:RW]))
    |=> take_cnt == CW'(1));

  // R10
  issue_count_chk: assert property (@(posedge clk) disable iff (!rstn_q)
    (|fp16_issue) |-> $countones(fp16_issue) == int'(take_cnt));
endmodule

// File: tb/cois_selector_test.sv
module cois_selector_test;
  localparam int PERIOD = 10;
  localparam int W = 4, RW = 5, IW = 2, CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #(PERIOD/2) clk = ~clk;

  logic [W-1:0]  v, f;
  logic [RW-1:0] d [W];
  logic [RW-1:0] a [W];
  logic [RW-1:0] b [W];
  logic [W*RW-1:0] dv, av, bv;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      dv[i*RW +: RW] = d[i];
      av[i*RW +: RW] = a[i];
      bv[i*RW +: RW] = b[i];
    end
  end

  logic [1:0] f32_en;  logic [3:0] f32_sl;
  logic [3:0] f16_en;  logic [7:0] f16_sl;
  logic [CW-1:0] cnt;  logic st;
  logic [1:0] s32_en;  logic [3:0] s32_sl;
  logic [1:0] s16_en;  logic [3:0] s16_sl;
  logic [CW-1:0] s_cnt; logic s_st;

  cois_selector #(.W(W), .RW(RW), .N_F32(2), .N_F16(4)) uut (
    .clk(clk), .rst_n(rst_n), .win_valid(v), .win_fp16(f),
    .win_dst(dv), .win_src_a(av), .win_src_b(bv),
    .fp32_issue(f32_en), .fp32_slot(f32_sl), .fp16_issue(f16_en), .fp16_slot(f16_sl),
    .take_cnt(cnt), .stall(st));

  cois_selector #(.W(W), .RW(RW), .N_F32(2), .N_F16(2)) uut_small (
    .clk(clk), .rst_n(rst_n), .win_valid(v), .win_fp16(f),
    .win_dst(dv), .win_src_a(av), .win_src_b(bv),
    .fp32_issue(s32_en), .fp32_slot(s32_sl), .fp16_issue(s16_en), .fp16_slot(s16_sl),
    .take_cnt(s_cnt), .stall(s_st));

  int tests = 0, fails = 0;
  bit done = 0;
  int p_n, p_ns; bit p_f16, p_v0; string p_why, p_whys;

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_take(int cap16, output string why);
    int cap, n;
    why = "R8";
    if (!v[0]) begin why = "R2"; return 0; end
    cap = f[0] ? cap16 : 2;
    n = 1;
    for (int j = 1; j < W; j++) begin
      bit stop = 0;
      if (j >= cap) begin why = f[0] ? "R4" : "R3"; break; end
      if (!v[j]) begin why = "R8"; break; end
      if (f[j] != f[0]) begin why = "R5"; break; end
      for (int i = 0; i < j; i++) begin
        if (d[i] == a[j] || d[i] == b[j]) begin why = "R6"; stop = 1; end
        else if (d[i] == d[j] && !stop) begin why = "R7"; stop = 1; end
      end
      if (stop) break;
      n++;
    end
    return n;
  endfunction

  function automatic int mask(int n, bit on, int width);
    int m = 0;
    if (on) for (int k = 0; k < width && k < n; k++) m |= (1 << k);
    return m;
  endfunction

  function automatic int slots(int m, int width);
    int s = 0;
    for (int k = 0; k < width; k++) if (m[k]) s |= (k << (k*IW));
    return s;
  endfunction

  task automatic compare(string tag);
    string t = (tag == "") ? p_why : tag;
    int m32 = mask(p_n, !p_f16, 2), m16 = mask(p_n, p_f16, 4);
    int sm16 = mask(p_ns, p_f16, 2), sm32 = mask(p_ns, !p_f16, 2);
    chk(t, "take_cnt", int'(cnt), p_n);
    chk("R2", "stall", int'(st), int'(!p_v0));
    chk("R10", "fp32_issue", int'(f32_en), m32);
    chk("R10", "fp16_issue", int'(f16_en), m16);
    chk("R10", "fp32_slot", int'(f32_sl), slots(m32, 2));
    chk("R10", "fp16_slot", int'(f16_sl), slots(m16, 4));
    if (tag == "" && p_v0) chk("R1", "take_cnt nonzero", int'(cnt != 0), 1);
    chk("R13", "small take_cnt", int'(s_cnt), p_ns);
    chk("R13", "small fp16_issue", int'(s16_en), sm16);
    chk("R13", "small fp32_issue", int'(s32_en), sm32);
    chk("R13", "small fp16_slot", int'(s16_sl), slots(sm16, 2));
    chk("R13", "small stall", int'(s_st), int'(!p_v0));
  endtask

  // window is set at a falling edge; result checked at the next falling edge
  task automatic step(string tag);
    p_n = ref_take(4, p_why);
    p_ns = ref_take(2, p_whys);
    p_f16 = f[0]; p_v0 = v[0];
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clr();
    v = '0; f = '0;
    for (int i = 0; i < W; i++) begin
      d[i] = RW'(8 + i); a[i] = RW'(16 + i); b[i] = RW'(24 + i);
    end
  endtask

  task automatic fill(bit vv, bit ff);
    clr();
    v = {W{vv}}; f = {W{ff}};
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clr();
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11", "reset take_cnt", int'(cnt), 0);
    chk("R11", "reset stall", int'(st), 0);
    chk("R11", "reset enables", int'({f32_en, f16_en}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    p_n = 0; p_ns = 0; p_f16 = 0; p_v0 = 0; p_why = "R2";
    compare("R2");

    fill(1, 0); step("R3");                 // four independent FP32 -> 2
    fill(1, 1); step("R12");                // four independent FP16 -> 4 (small: 2)
    fill(1, 1); step("R4");
    clr(); step("R2");                      // R11: previous window's result gone
    fill(1, 0); step("R11");
    fill(1, 1); f[2] = 1'b0; step("R5");    // F16 F16 F32 F16 -> 2
    fill(1, 0); f[0] = 1'b1; step("R5");    // F16 head then F32 -> 1
    fill(1, 0); b[1] = d[0]; step("R6");    // RAW on source B -> 1
    fill(1, 1); a[2] = d[1]; step("R6");    // RAW on entry 2 -> 2
    fill(1, 1); a[3] = d[0]; step("R6");    // RAW on entry 3 -> 3
    fill(1, 1); d[1] = d[0]; step("R7");    // WAW -> 1
    fill(1, 1); d[2] = d[0]; step("R7");    // WAW -> 2
    fill(1, 1); v[1] = 1'b0; step("R8");    // gap, no skipping -> 1
    fill(1, 1); v[3] = 1'b0; step("R8");    // -> 3
    fill(1, 0); d[0] = '0; a[1] = '0; step("R9");
    fill(1, 1); d[1] = '0; b[2] = '0; step("R9");
    fill(1, 1); a[0] = d[0]; b[1] = d[1]; a[2] = d[2]; b[3] = d[3]; step("R12");
    fill(0, 1); step("R2");

    for (int c = 0; c < 400; c++) begin
      v = W'($urandom); f = W'($urandom);
      if (c % 3 == 0) v = '1;
      for (int i = 0; i < W; i++) begin
        bit wide = ($urandom_range(0, 9) < 3);
        d[i] = wide ? RW'($urandom) : RW'($urandom_range(0, 3));
        a[i] = wide ? RW'($urandom) : RW'($urandom_range(0, 5));
        b[i] = wide ? RW'($urandom) : RW'($urandom_range(0, 5));
      end
      step("");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule